// File: doc/BRIEF.md
# MMIO Region Decoder with Access Tracing

This block sits between a processor's load/store path and a set of memory-mapped register blocks. Each accepted access is classified by its physical page into a numbered region. A write or read strobe goes to the register-block port that owns that page, together with the in-page offset and the write data. Read data comes back through a multiplexer. That multiplexer is steered by the region captured when the read was accepted, not by whatever address is on the bus later.

In the same cycle as acceptance, the block emits one trace event. For a mapped access the event is a read or write tagged with the region number. For an access that hits no page, or hits a page the trace classifier does not recognise, the event is an unmapped event. An unmapped read still completes, with zero data, so the requester never stalls.

The default configuration decodes eight consecutive 4 KiB pages, 0x1000_8000 through 0x1000_F000, as regions 7 to 14. The DMA global control page at 0x1000_E000 is region 13.

Top module: `mmio_region_decoder`

## Requirements
- R1: A hit compares only address bits 28:12 with the page base. Bits 31:29 and bits 11:0 never change the selected region, and port_offset carries bits 11:0 of the accepted address.
- R2: Port i (0..7) owns page 0x10008+i and reports region number 7+i. Address 0x1000_E000 is region 13. Addresses 0x1000_F000, 0x1000_F400 and 0x1000_F800 all fall in region 14.
- R3: At most one port strobe (port_rd_en or port_wr_en bit) is high in any cycle. A mapped write raises only port_wr_en[i] with port_wdata equal to the request data. A mapped read raises only port_rd_en[i].
- R4: A mapped access makes trace_valid high in its acceptance cycle. trace_kind is 1 for a read and 2 for a write, trace_addr is the full address, and trace_region is the region number.
- R5: An access that hits no page gives trace_kind 3 and trace_region 0, and strobes no port. trace_is_write gives the access direction for every event.
- R6: An unmapped read returns rsp_valid high with rsp_data zero in the cycle after acceptance.
- R7: A mapped read completes in the cycle its own port raises port_rd_valid, with that port's data. port_rd_valid from any other port has no effect on rsp_valid.
- R8: req_ready drops in the cycle after a read is accepted and rises in the cycle after the response. Writes never lower req_ready.
- R9: A routed port whose TRACE_KNOWN bit is 0 still receives its strobe, but its events are reported with trace_kind 3 and trace_region 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Physical address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request can be accepted |
| port_wr_en | output | NPORT | Per-port write strobe |
| port_rd_en | output | NPORT | Per-port read strobe |
| port_offset | output | 12 | In-page offset |
| port_wdata | output | DW | Write data to ports |
| port_rd_valid | input | NPORT | Per-port read completion |
| port_rd_data | input | NPORT*DW | Per-port read data, port i at bits [i*DW +: DW] |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DW | Read response data |
| trace_valid | output | 1 | Trace event strobe |
| trace_kind | output | 2 | 1 read, 2 write, 3 unmapped |
| trace_is_write | output | 1 | Access direction of the event |
| trace_addr | output | AW | Full access address |
| trace_region | output | 8 | Region number, 0 when unmapped |

## Verification
The trace event and the port strobe for one access appear in the same cycle. The bench drives each request and, in that cycle, checks both against values computed from the page arithmetic, so a region that is routed but not traced, or traced but not routed, shows up as a mismatch. A second coincidence is checked while a mapped read is pending: another port raises its read-valid in that window. The bench drives such a decoy completion one cycle before the real one. It expects no response on the decoy cycle, then the latched port's data on the next.

// File: rtl/mmio_region_decoder.sv
module mmio_region_decoder #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NPORT     = 8,
  parameter int PAGE_MSB  = 28,
  parameter int PAGE_LSB  = 12,
  parameter int BASE_PAGE = 'h10008,
  parameter int FIRST_ID  = 7,
  parameter logic [NPORT-1:0] TRACE_KNOWN = {NPORT{1'b1}}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                req_ready,
  output logic [NPORT-1:0]    port_wr_en,
  output logic [NPORT-1:0]    port_rd_en,
  output logic [11:0]         port_offset,
  output logic [DW-1:0]       port_wdata,
  input  logic [NPORT-1:0]    port_rd_valid,
  input  logic [NPORT*DW-1:0] port_rd_data,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_data,
  output logic                trace_valid,
  output logic [1:0]          trace_kind,
  output logic                trace_is_write,
  output logic [AW-1:0]       trace_addr,
  output logic [7:0]          trace_region
);
  localparam int PW = PAGE_MSB - PAGE_LSB + 1;
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam logic [1:0] K_RD = 2'd1, K_WR = 2'd2, K_UNM = 2'd3;

  logic [NPORT-1:0] hit_vec;
  logic [IW-1:0]    hit_idx;
  logic             hit, known, accept;
  logic             rd_pend, rd_unm;
  logic [IW-1:0]    rd_sel;

  for (genvar i = 0; i < NPORT; i++) begin : g_match
    assign hit_vec[i] = req_addr[PAGE_MSB:PAGE_LSB] == PW'(BASE_PAGE + i);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NPORT; i++)
      if (hit_vec[i]) hit_idx = IW'(i);
  end

  assign hit    = |hit_vec;
  assign known  = hit && TRACE_KNOWN[hit_idx];
  assign accept = req_valid && req_ready;

  assign req_ready   = !rd_pend;
  assign port_wr_en  = (accept && req_write)  ? hit_vec : '0;
  assign port_rd_en  = (accept && !req_write) ? hit_vec : '0;
  assign port_offset = req_addr[11:0];
  assign port_wdata  = req_wdata;

  assign trace_valid    = accept;
  assign trace_is_write = req_write;
  assign trace_addr     = req_addr;
  assign trace_kind     = !known ? K_UNM : (req_write ? K_WR : K_RD);
  assign trace_region   = known ? 8'(FIRST_ID + int'(hit_idx)) : 8'd0;

  assign rsp_valid = rd_pend && (rd_unm || port_rd_valid[rd_sel]);
  assign rsp_data  = (rd_pend && !rd_unm) ? port_rd_data[rd_sel*DW +: DW] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_unm  <= 1'b0;
      rd_sel  <= '0;
    end else if (accept && !req_write) begin
      rd_pend <= 1'b1;
      rd_unm  <= !hit;
      rd_sel  <= hit_idx;
    end else if (rsp_valid) begin
      rd_pend <= 1'b0;
    end
  end
endmodule

module mmio_region_decoder_chk #(
  parameter int NPORT = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_ready,
  input logic [NPORT-1:0] port_wr_en,
  input logic [NPORT-1:0] port_rd_en,
  input logic             rsp_valid,
  input logic [DW-1:0]    rsp_data,
  input logic             trace_valid,
  input logic [1:0]       trace_kind
);
  assert_single_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_wr_en | port_rd_en));

  assert_trace_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trace_valid |-> req_valid);

  assert_mapped_routed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_valid && trace_kind != 2'd3) |-> $countones(port_wr_en | port_rd_en) == 1);

  assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_valid && !req_write && port_rd_en == '0) |=> (rsp_valid && rsp_data == '0));

  assert_read_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_valid && !req_write) |=> !req_ready);

  assert_write_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_valid && req_write) |=> req_ready);
endmodule

bind mmio_region_decoder mmio_region_decoder_chk #(.NPORT(NPORT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .port_wr_en(port_wr_en), .port_rd_en(port_rd_en),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .trace_valid(trace_valid),
  .trace_kind(trace_kind)
);

// File: tb/mmio_region_decoder_bench.sv
module mmio_region_decoder_bench;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, m_req_valid = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [N-1:0] prv = 0;
  logic [N*32-1:0] prd;
  logic req_ready, rsp_valid, trace_valid, trace_is_write;
  logic [N-1:0] pwe, pre;
  logic [11:0] poff;
  logic [31:0] pwd, rsp_data, trace_addr;
  logic [1:0] trace_kind;
  logic [7:0] trace_region;

  logic m_ready, m_rsp_valid, m_tv, m_tw;
  logic [N-1:0] m_pwe, m_pre;
  logic [11:0] m_poff;
  logic [31:0] m_pwd, m_rsp_data, m_ta;
  logic [1:0] m_tk;
  logic [7:0] m_tr;

  int errors = 0, checks = 0, cycles = 0;

  for (genvar i = 0; i < N; i++) begin : g_data
    assign prd[i*32 +: 32] = 32'hC0DE_0000 + 32'(i) * 32'h111;
  end

  mmio_region_decoder u_mmio_region_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .port_wr_en(pwe), .port_rd_en(pre), .port_offset(poff), .port_wdata(pwd),
    .port_rd_valid(prv), .port_rd_data(prd), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .trace_valid(trace_valid), .trace_kind(trace_kind),
    .trace_is_write(trace_is_write), .trace_addr(trace_addr),
    .trace_region(trace_region));

  mmio_region_decoder #(.TRACE_KNOWN(8'b1011_1111)) u_mmio_region_decoder_masked (
    .clk(clk), .rst_n(rst_n), .req_valid(m_req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(m_ready),
    .port_wr_en(m_pwe), .port_rd_en(m_pre), .port_offset(m_poff), .port_wdata(m_pwd),
    .port_rd_valid('0), .port_rd_data(prd), .rsp_valid(m_rsp_valid),
    .rsp_data(m_rsp_data), .trace_valid(m_tv), .trace_kind(m_tk),
    .trace_is_write(m_tw), .trace_addr(m_ta), .trace_region(m_tr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] data);
    int page = int'(addr[28:12]);
    int p = page - 'h10008;
    logic mapped = (p >= 0 && p < N);
    logic [N-1:0] onehot = mapped ? (N'(1) << p) : '0;
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = data;
    #1;
    chk("R4 trace_valid", 64'(trace_valid), 64'd1);
    chk("R5 trace_is_write", 64'(trace_is_write), 64'(wr));
    chk("R4 trace_addr", 64'(trace_addr), 64'(addr));
    chk("R4 R5 trace_kind", 64'(trace_kind), mapped ? (wr ? 64'd2 : 64'd1) : 64'd3);
    chk("R2 trace_region", 64'(trace_region), mapped ? 64'(7 + p) : 64'd0);
    chk("R3 port_wr_en", 64'(pwe), wr ? 64'(onehot) : 64'd0);
    chk("R3 port_rd_en", 64'(pre), wr ? 64'd0 : 64'(onehot));
    chk("R1 port_offset", 64'(poff), 64'(addr[11:0]));
    if (wr) chk("R3 port_wdata", 64'(pwd), 64'(data));
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    #1;
    if (wr) begin
      chk("R8 ready after write", 64'(req_ready), 64'd1);
    end else if (!mapped) begin
      chk("R8 ready low", 64'(req_ready), 64'd0);
      chk("R6 rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R6 rsp_data", 64'(rsp_data), 64'd0);
      @(posedge clk); @(negedge clk); #1;
      chk("R8 ready back", 64'(req_ready), 64'd1);
    end else begin
      chk("R8 ready low", 64'(req_ready), 64'd0);
      prv = N'(1) << ((p + 1) % N);
      #1;
      chk("R7 decoy ignored", 64'(rsp_valid), 64'd0);
      @(posedge clk); @(negedge clk);
      prv = N'(1) << p;
      #1;
      chk("R7 rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R7 rsp_data", 64'(rsp_data), 64'(32'hC0DE_0000 + 32'(p) * 32'h111));
      @(posedge clk); @(negedge clk);
      prv = 0;
      #1;
      chk("R8 ready back", 64'(req_ready), 64'd1);
      chk("R7 no extra rsp", 64'(rsp_valid), 64'd0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset ready", 64'(req_ready), 64'd1);
    chk("R6 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R4 reset trace_valid", 64'(trace_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    // sweep pages around the window, upper and low bits varied (R1, R2)
    for (int k = 0; k < 32; k++) begin
      logic [31:0] a = {3'(k * 5), 17'h10000 + 17'(k), 12'(k * 149)};
      access(1'b1, a, 32'h5A00_0000 ^ 32'(k * 77));
      access(1'b0, a, 32'h0);
    end
    // region 14 page spans three channel bases; region 13 control page (R2)
    access(1'b0, 32'h1000_F400, 0);
    access(1'b1, 32'h1000_F800, 32'h1234);
    access(1'b0, 32'h1000_E000, 0);
    access(1'b0, 32'hB000_E010, 0);
    access(1'b0, 32'h1001_0000, 0);
    access(1'b0, 32'h0000_E000, 0);
    // R9: port 6 routed but not trace-known in the masked instance
    req_write = 1; req_addr = 32'h1000_E010; req_wdata = 32'h77;
    m_req_valid = 1;
    #1;
    chk("R9 masked kind", 64'(m_tk), 64'd3);
    chk("R9 masked region", 64'(m_tr), 64'd0);
    chk("R9 masked still routed", 64'(m_pwe), 64'h40);
    @(posedge clk); @(negedge clk);
    req_addr = 32'h1000_D000;
    #1;
    chk("R9 known port kind", 64'(m_tk), 64'd2);
    chk("R9 known port region", 64'(m_tr), 64'd12);
    @(posedge clk); @(negedge clk);
    m_req_valid = 0;
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule